// File: doc/BRIEF.md
# Shared Memory Ownership Guard

This block decides whether a memory access to one of several shared RAM blocks may proceed. Two processor subsystems, A and B, can reach these blocks. Each subsystem has a CPU and a DMA engine. Every block belongs to exactly one subsystem. The owner gets full use of the block and the other subsystem may only read it. Each request names the subsystem, the requester (CPU or DMA), the access kind and the target block. The guard answers with a grant or a refusal in the same cycle. A refusal raises a one-cycle violation flag, and the details of the first offending access are kept in a log until software clears it.

Ownership is set through a select register that only subsystem A's configuration port can write. Subsystem B sees a read-only mirror of the select register. A lock bit freezes the select register. Software cannot clear the lock; only the dedicated shared-resource reset releases it. Each subsystem also holds a protection register with three enables per block. The enables that apply to a block are always taken from the register of the subsystem that currently owns that block.

Top module: `shram_guard`

## Requirements
- R1: Ownership bit i set to 0 gives block i to subsystem A, and 1 gives it to subsystem B. With its protection enables clear, the owner's CPU is granted fetch (type code 0), read (1) and write (2).
- R2: With its protection enables clear, the owner's DMA is granted read and write. A DMA fetch is always refused.
- R3: A request from the subsystem that does not own the block is granted for a read and refused for a fetch or a write, whatever the requester.
- R4: Port A writes the select register at address 0, with the select bits in data[NUM_BLOCKS-1:0]. A write from port B to address 0 has no effect. `ownerStatusB` always shows the current select bits.
- R5: The lock lives in data bit NUM_BLOCKS of the address-0 write. Once the lock is set, later select writes are ignored, and a write carrying a 0 lock bit leaves the lock set.
- R6: A select value written in the same write that sets the lock is accepted.
- R7: `sharedRstN` clears the select bits, the lock and both protection registers. `rstN` leaves them unchanged and only empties the violation log.
- R8: Each subsystem's protection register is written at address 1 through its own port. For block i, bit 3i blocks CPU writes, bit 3i+1 blocks CPU fetches and bit 3i+2 blocks DMA writes.
- R9: The protection enables that apply to block i come from the owner's register. Enables in the non-owner's register have no effect.
- R10: `accessOk` and `violation` are combinational. `violation` is high exactly in a cycle where `reqValid` is high and the access is refused.
- R11: On a violation with the log empty, the log captures block, type, side and master and sets `vioHeld`. Later violations do not change the log until `vioClear`. A violation in the clear cycle is captured.
- R12: A request with type code 3, or with a block index at or above NUM_BLOCKS, is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the violation log |
| sharedRstN | input | 1 | Active-low shared-resource reset of ownership, lock and protections |
| aCfgWe | input | 1 | Port A configuration write strobe |
| aCfgAddr | input | 1 | Port A register select: 0 select/lock, 1 protection |
| aCfgData | input | 3*NUM_BLOCKS | Port A write data |
| bCfgWe | input | 1 | Port B configuration write strobe |
| bCfgAddr | input | 1 | Port B register select (only 1 is effective) |
| bCfgData | input | 3*NUM_BLOCKS | Port B write data |
| reqValid | input | 1 | An access request is present |
| reqSide | input | 1 | Requesting subsystem: 0 A, 1 B |
| reqMaster | input | 1 | Requester: 0 CPU, 1 DMA |
| reqType | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| reqBlock | input | IDX_W | Target block index |
| vioClear | input | 1 | Empties the violation log |
| accessOk | output | 1 | Request granted |
| violation | output | 1 | Request refused (one-cycle pulse per refused cycle) |
| ownerSelA | output | NUM_BLOCKS | Select register as read by port A |
| lockRd | output | 1 | Lock state |
| ownerStatusB | output | NUM_BLOCKS | Ownership mirror for subsystem B |
| protARd | output | 3*NUM_BLOCKS | Subsystem A protection register |
| protBRd | output | 3*NUM_BLOCKS | Subsystem B protection register |
| vioHeld | output | 1 | Log holds a violation |
| vioBlock | output | IDX_W | Logged block index |
| vioType | output | 2 | Logged access type |
| vioSide | output | 1 | Logged subsystem |
| vioMaster | output | 1 | Logged requester |

## Verification
The grant and the violation flag are due in the same cycle the request is driven. The bench drives each request just after a falling edge and compares the outputs a few nanoseconds later, before the next rising edge can change any configuration. Register effects (select, lock, protections, the log) are due one rising edge after the write, clear or refused request. Those checks wait for the next falling edge after that rising edge. A reference model in the bench tracks the select, lock and protection values and computes every expected decision from the requirements.

// File: rtl/shram_guard_pkg.sv
package shram_guard_pkg;

  // Access kinds carried on reqType
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Bit positions inside a block's three-bit protection slice
  localparam int PROT_CPU_WR    = 0;
  localparam int PROT_CPU_FETCH = 1;
  localparam int PROT_DMA_WR    = 2;
  localparam int PROT_BITS      = 3;

  // Configuration register addresses
  localparam logic REG_SEL  = 1'b0;
  localparam logic REG_PROT = 1'b1;

  // Requester encodings
  localparam logic SIDE_A     = 1'b0;
  localparam logic MASTER_CPU = 1'b0;
  localparam logic MASTER_DMA = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic selWe;
    logic lockSet;
    logic protAWe;
    logic protBWe;
    logic vioCapture;
    logic vioClear;
  } guard_strobe_t;

endpackage

// File: rtl/shram_guard_perm.sv
module shram_guard_perm
  import shram_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = 3,
  parameter int CFG_W      = 3 * NUM_BLOCKS
) (
  input  logic [NUM_BLOCKS-1:0] ownerSel,
  input  logic [CFG_W-1:0]      protA,
  input  logic [CFG_W-1:0]      protB,
  input  logic                  reqValid,
  input  logic                  reqSide,
  input  logic                  reqMaster,
  input  logic [1:0]            reqType,
  input  logic [IDX_W-1:0]      reqBlock,
  output logic                  accessOk,
  output logic                  deny
);

  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] slotOk;
  acc_e             kind;

  assign kind = acc_e'(reqType);

  // One decision per addressable slot; slots past the last block refuse.
  for (genvar b = 0; b < SLOTS; b++) begin : g_slot
    if (b < NUM_BLOCKS) begin : g_real
      logic                 owner;
      logic                 isOwner;
      logic [PROT_BITS-1:0] pr;

      assign owner   = ownerSel[b];
      assign isOwner = (reqSide == owner);
      assign pr      = owner ? protB[b*PROT_BITS +: PROT_BITS]
                             : protA[b*PROT_BITS +: PROT_BITS];

      always_comb begin
        slotOk[b] = 1'b0;
        if (!isOwner) begin
          slotOk[b] = (kind == ACC_READ);
        end else if (reqMaster == MASTER_CPU) begin
          unique case (kind)
            ACC_FETCH: slotOk[b] = !pr[PROT_CPU_FETCH];
            ACC_READ:  slotOk[b] = 1'b1;
            ACC_WRITE: slotOk[b] = !pr[PROT_CPU_WR];
            default:   slotOk[b] = 1'b0;
          endcase
        end else begin
          unique case (kind)
            ACC_READ:  slotOk[b] = 1'b1;
            ACC_WRITE: slotOk[b] = !pr[PROT_DMA_WR];
            default:   slotOk[b] = 1'b0;
          endcase
        end
      end
    end else begin : g_pad
      assign slotOk[b] = 1'b0;
    end
  end

  assign accessOk = reqValid && slotOk[reqBlock];
  assign deny     = reqValid && !slotOk[reqBlock];

endmodule

// File: rtl/shram_guard_ctrl.sv
module shram_guard_ctrl
  import shram_guard_pkg::*;
(
  input  logic          aCfgWe,
  input  logic          aCfgAddr,
  input  logic          aLockBit,
  input  logic          bCfgWe,
  input  logic          bCfgAddr,
  input  logic          lockState,
  input  logic          deny,
  input  logic          vioHeld,
  input  logic          vioClear,
  output guard_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    // Select writes only from port A, and only while unlocked; the lock
    // is sampled before this write, so a locking write still lands.
    strobe.selWe   = aCfgWe && (aCfgAddr == REG_SEL) && !lockState;
    strobe.lockSet = aCfgWe && (aCfgAddr == REG_SEL) && aLockBit && !lockState;
    strobe.protAWe = aCfgWe && (aCfgAddr == REG_PROT);
    strobe.protBWe = bCfgWe && (bCfgAddr == REG_PROT);
    // Keep the first refusal; a clear frees the log in the same cycle.
    strobe.vioCapture = deny && (!vioHeld || vioClear);
    strobe.vioClear   = vioClear;
  end

endmodule

// File: rtl/shram_guard_dp.sv
module shram_guard_dp
  import shram_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = 3,
  parameter int CFG_W      = 3 * NUM_BLOCKS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sharedRstN,
  input  guard_strobe_t         strobe,
  input  logic [CFG_W-1:0]      aCfgData,
  input  logic [CFG_W-1:0]      bCfgData,
  input  logic                  reqSide,
  input  logic                  reqMaster,
  input  logic [1:0]            reqType,
  input  logic [IDX_W-1:0]      reqBlock,
  output logic [NUM_BLOCKS-1:0] ownerSel,
  output logic                  lockState,
  output logic [CFG_W-1:0]      protA,
  output logic [CFG_W-1:0]      protB,
  output logic                  vioHeld,
  output logic [IDX_W-1:0]      vioBlock,
  output logic [1:0]            vioType,
  output logic                  vioSide,
  output logic                  vioMaster
);

  // Ownership and lock: only the shared-resource reset clears them
  always_ff @(posedge clk or negedge sharedRstN) begin
    if (!sharedRstN) begin
      ownerSel  <= '0;
      lockState <= 1'b0;
    end else begin
      if (strobe.selWe)   ownerSel  <= aCfgData[NUM_BLOCKS-1:0];
      if (strobe.lockSet) lockState <= 1'b1;
    end
  end

  // Per-subsystem protection enables
  always_ff @(posedge clk or negedge sharedRstN) begin
    if (!sharedRstN) begin
      protA <= '0;
      protB <= '0;
    end else begin
      if (strobe.protAWe) protA <= aCfgData;
      if (strobe.protBWe) protB <= bCfgData;
    end
  end

  // Violation log
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vioHeld   <= 1'b0;
      vioBlock  <= '0;
      vioType   <= '0;
      vioSide   <= 1'b0;
      vioMaster <= 1'b0;
    end else if (strobe.vioCapture) begin
      vioHeld   <= 1'b1;
      vioBlock  <= reqBlock;
      vioType   <= reqType;
      vioSide   <= reqSide;
      vioMaster <= reqMaster;
    end else if (strobe.vioClear) begin
      vioHeld   <= 1'b0;
    end
  end

endmodule

// File: rtl/shram_guard.sv
module shram_guard
  import shram_guard_pkg::*;
#(
  parameter  int NUM_BLOCKS = 6,
  localparam int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int CFG_W      = 3 * NUM_BLOCKS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sharedRstN,
  input  logic                  aCfgWe,
  input  logic                  aCfgAddr,
  input  logic [CFG_W-1:0]      aCfgData,
  input  logic                  bCfgWe,
  input  logic                  bCfgAddr,
  input  logic [CFG_W-1:0]      bCfgData,
  input  logic                  reqValid,
  input  logic                  reqSide,
  input  logic                  reqMaster,
  input  logic [1:0]            reqType,
  input  logic [IDX_W-1:0]      reqBlock,
  input  logic                  vioClear,
  output logic                  accessOk,
  output logic                  violation,
  output logic [NUM_BLOCKS-1:0] ownerSelA,
  output logic                  lockRd,
  output logic [NUM_BLOCKS-1:0] ownerStatusB,
  output logic [CFG_W-1:0]      protARd,
  output logic [CFG_W-1:0]      protBRd,
  output logic                  vioHeld,
  output logic [IDX_W-1:0]      vioBlock,
  output logic [1:0]            vioType,
  output logic                  vioSide,
  output logic                  vioMaster
);

  guard_strobe_t         strobe;
  logic [NUM_BLOCKS-1:0] ownerSel;
  logic                  lockState;
  logic [CFG_W-1:0]      protA;
  logic [CFG_W-1:0]      protB;
  logic                  deny;

  shram_guard_perm #(
    .NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .CFG_W(CFG_W)
  ) u_perm (
    .ownerSel (ownerSel),
    .protA    (protA),
    .protB    (protB),
    .reqValid (reqValid),
    .reqSide  (reqSide),
    .reqMaster(reqMaster),
    .reqType  (reqType),
    .reqBlock (reqBlock),
    .accessOk (accessOk),
    .deny     (deny)
  );

  shram_guard_ctrl u_ctrl (
    .aCfgWe   (aCfgWe),
    .aCfgAddr (aCfgAddr),
    .aLockBit (aCfgData[NUM_BLOCKS]),
    .bCfgWe   (bCfgWe),
    .bCfgAddr (bCfgAddr),
    .lockState(lockState),
    .deny     (deny),
    .vioHeld  (vioHeld),
    .vioClear (vioClear),
    .strobe   (strobe)
  );

  shram_guard_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .CFG_W(CFG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sharedRstN(sharedRstN),
    .strobe    (strobe),
    .aCfgData  (aCfgData),
    .bCfgData  (bCfgData),
    .reqSide   (reqSide),
    .reqMaster (reqMaster),
    .reqType   (reqType),
    .reqBlock  (reqBlock),
    .ownerSel  (ownerSel),
    .lockState (lockState),
    .protA     (protA),
    .protB     (protB),
    .vioHeld   (vioHeld),
    .vioBlock  (vioBlock),
    .vioType   (vioType),
    .vioSide   (vioSide),
    .vioMaster (vioMaster)
  );

  assign violation    = deny;
  assign ownerSelA    = ownerSel;
  assign ownerStatusB = ownerSel;
  assign lockRd       = lockState;
  assign protARd      = protA;
  assign protBRd      = protB;

endmodule

// File: rtl/shram_guard_chk.sv
module shram_guard_chk #(
  parameter  int NUM_BLOCKS = 6,
  localparam int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sharedRstN,
  input logic                  aCfgWe,
  input logic                  reqValid,
  input logic                  reqSide,
  input logic                  reqMaster,
  input logic [1:0]            reqType,
  input logic [IDX_W-1:0]      reqBlock,
  input logic                  vioClear,
  input logic                  accessOk,
  input logic                  violation,
  input logic [NUM_BLOCKS-1:0] ownerSelA,
  input logic                  lockRd,
  input logic                  vioHeld
);

  // R3
  nonowner_write_denied_chk: assert property (@(posedge clk) disable iff (!sharedRstN)
    (reqValid && reqType == 2'd2 && int'(reqBlock) < NUM_BLOCKS
      && reqSide != ownerSelA[reqBlock]) |-> !accessOk);

  // R2
  dma_fetch_denied_chk: assert property (@(posedge clk) disable iff (!sharedRstN)
    (reqValid && reqMaster && reqType == 2'd0) |-> !accessOk);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!sharedRstN)
    lockRd |=> lockRd);

  // R5
  locked_sel_stable_chk: assert property (@(posedge clk) disable iff (!sharedRstN)
    lockRd |=> $stable(ownerSelA));

  // R4
  sel_only_from_a_chk: assert property (@(posedge clk) disable iff (!sharedRstN)
    !aCfgWe |=> $stable(ownerSelA));

  // R11
  vio_logged_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> vioHeld);

  // R11
  vio_held_until_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vioHeld && !vioClear) |=> vioHeld);

endmodule

bind shram_guard shram_guard_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (.*);

// File: tb/shram_guard_bench.sv
module shram_guard_bench;

  localparam int NB    = 6;
  localparam int IDX_W = 3;
  localparam int CFG_W = 3 * NB;

  logic clk = 1'b0;
  logic rstN = 1'b0, sharedRstN = 1'b0;
  logic aCfgWe = 0, aCfgAddr = 0, bCfgWe = 0, bCfgAddr = 0;
  logic [CFG_W-1:0] aCfgData = '0, bCfgData = '0;
  logic reqValid = 0, reqSide = 0, reqMaster = 0, vioClear = 0;
  logic [1:0] reqType = '0;
  logic [IDX_W-1:0] reqBlock = '0;
  logic accessOk, violation, lockRd, vioHeld, vioSide, vioMaster;
  logic [NB-1:0] ownerSelA, ownerStatusB;
  logic [CFG_W-1:0] protARd, protBRd;
  logic [IDX_W-1:0] vioBlock;
  logic [1:0] vioType;

  always #10 clk = ~clk;  // 50 MHz

  shram_guard #(.NUM_BLOCKS(NB)) u_shram_guard (.*);

  int tests = 0, fails = 0;

  // Reference model state
  logic [NB-1:0]    mOwner = '0;
  logic             mLock  = 1'b0;
  logic [CFG_W-1:0] mProtA = '0, mProtB = '0;

  typedef struct { string tag; logic expOk; } item_t;
  item_t q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic modelOk(int side, int master, int typ, int blk);
    logic own;
    logic [2:0] pr;
    if (typ == 3 || blk >= NB) return 1'b0;
    own = mOwner[blk];
    pr  = own ? mProtB[3*blk +: 3] : mProtA[3*blk +: 3];
    if (side != int'(own)) return (typ == 1);
    if (master == 0) begin
      if (typ == 0) return !pr[1];
      if (typ == 1) return 1'b1;
      return !pr[0];
    end
    if (typ == 1) return 1'b1;
    if (typ == 2) return !pr[2];
    return 1'b0;
  endfunction

  function automatic string modelTag(int side, int master, int typ, int blk);
    logic own;
    if (typ == 3 || blk >= NB) return "R12";
    own = mOwner[blk];
    if (side != int'(own)) return "R3";
    if ((own ? mProtB[3*blk +: 3] : mProtA[3*blk +: 3]) != 3'b000) return "R8/R9";
    return (master == 0) ? "R1" : "R2";
  endfunction

  // Driver: one request per cycle, expected result queued
  task automatic req(int side, int master, int typ, int blk, logic clr);
    item_t it;
    @(negedge clk);
    reqValid = 1; reqSide = side[0]; reqMaster = master[0];
    reqType = typ[1:0]; reqBlock = blk[IDX_W-1:0]; vioClear = clr;
    it.tag = modelTag(side, master, typ, blk);
    it.expOk = modelOk(side, master, typ, blk);
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 0; vioClear = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #3;
  endtask

  // Monitor: decision due in the same cycle as the request
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        tests++;
        if (accessOk !== it.expOk || violation !== !it.expOk) begin
          fails++;
          $display("FAIL %s R10 side=%0d master=%0d type=%0d blk=%0d actual ok=%b vio=%b expected ok=%b vio=%b",
                   it.tag, reqSide, reqMaster, reqType, reqBlock,
                   accessOk, violation, it.expOk, !it.expOk);
        end
      end
    end
  end

  task automatic cfgA(logic addr, logic [CFG_W-1:0] data);
    @(negedge clk);
    aCfgWe = 1; aCfgAddr = addr; aCfgData = data;
    @(negedge clk);
    aCfgWe = 0;
    if (addr == 1'b0) begin
      if (!mLock) mOwner = data[NB-1:0];
      if (data[NB]) mLock = 1'b1;
    end else mProtA = data;
  endtask

  task automatic cfgB(logic addr, logic [CFG_W-1:0] data);
    @(negedge clk);
    bCfgWe = 1; bCfgAddr = addr; bCfgData = data;
    @(negedge clk);
    bCfgWe = 0;
    if (addr == 1'b1) mProtB = data;
  endtask

  task automatic sweep();
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int t = 0; t < 4; t++)
          for (int b = 0; b < 8; b++)
            req(s, m, t, b, 1'b0);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; sharedRstN = 1;
    settle();
    // R7 reset state
    chk("R7 sel after reset", 32'(ownerSelA), 0);
    chk("R7 lock after reset", 32'(lockRd), 0);
    chk("R7 protA after reset", 32'(protARd), 0);
    chk("R11 log empty after reset", 32'(vioHeld), 0);

    // R1 R2 R3 R12: all blocks owned by A
    sweep();

    // R4 ownership from port A, mirrored to B
    cfgA(1'b0, CFG_W'(6'b101010));
    settle();
    chk("R4 sel written", 32'(ownerSelA), 32'h2a);
    chk("R4 mirror", 32'(ownerStatusB), 32'h2a);
    sweep();

    // R4 port B cannot write the select register
    cfgB(1'b0, '0);
    settle();
    chk("R4 port B ignored", 32'(ownerStatusB), 32'h2a);

    // R8 R9 protections: A enables all; B blocks cpu wr blk1, dma wr blk3, fetch blk5
    cfgA(1'b1, '1);
    cfgB(1'b1, CFG_W'((1 << 3) | (1 << 11) | (1 << 16)));
    settle();
    chk("R8 protA readback", 32'(protARd), 32'h3ffff);
    chk("R8 protB readback", 32'(protBRd), 32'((1 << 3) | (1 << 11) | (1 << 16)));
    sweep();

    // R11 violation log
    @(negedge clk); vioClear = 1;
    @(negedge clk); vioClear = 0;
    settle();
    chk("R11 cleared", 32'(vioHeld), 0);
    req(1, 0, 2, 0, 1'b0);   // B cpu write to A-owned block 0
    idle();
    settle();
    chk("R11 held", 32'(vioHeld), 1);
    chk("R11 block", 32'(vioBlock), 0);
    chk("R11 type", 32'(vioType), 2);
    chk("R11 side", 32'(vioSide), 1);
    chk("R11 master", 32'(vioMaster), 0);
    req(0, 1, 0, 3, 1'b0);   // DMA fetch: refused, log must keep first entry
    idle();
    settle();
    chk("R11 first kept", 32'(vioBlock), 0);
    req(0, 0, 3, 4, 1'b1);   // refusal in the clear cycle is captured
    idle();
    settle();
    chk("R11 capture on clear", 32'(vioBlock), 4);
    chk("R11 type on clear", 32'(vioType), 3);

    // R6 select accepted together with lock; R5 later writes ignored
    cfgA(1'b0, CFG_W'((1 << NB) | 6'b000111));
    settle();
    chk("R6 sel with lock", 32'(ownerSelA), 32'h07);
    chk("R5 lock set", 32'(lockRd), 1);
    cfgA(1'b0, CFG_W'(6'b111000));
    settle();
    chk("R5 locked sel", 32'(ownerSelA), 32'h07);
    chk("R5 lock kept", 32'(lockRd), 1);
    sweep();

    // R7 plain reset keeps configuration
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    settle();
    chk("R7 lock survives rstN", 32'(lockRd), 1);
    chk("R7 sel survives rstN", 32'(ownerSelA), 32'h07);
    chk("R7 log emptied by rstN", 32'(vioHeld), 0);

    // R7 shared reset clears everything
    @(negedge clk); sharedRstN = 0;
    @(negedge clk); sharedRstN = 1;
    mOwner = '0; mLock = 0; mProtA = '0; mProtB = '0;
    settle();
    chk("R7 lock cleared", 32'(lockRd), 0);
    chk("R7 sel cleared", 32'(ownerSelA), 0);
    chk("R7 protB cleared", 32'(protBRd), 0);
    cfgA(1'b0, CFG_W'(6'b010101));
    settle();
    chk("R5 writable after shared reset", 32'(ownerSelA), 32'h15);
    sweep();

    settle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule